// File: doc/BRIEF.md
# Paged Byte-Wide Boot Loader

This block fills a 24-bit wide, 1024-word program RAM from an external read-only memory that is only one byte wide. The external memory is split into eight pages of 4K bytes each. Inside a page, every program word sits in its own 4-byte slot. The first three bytes of a slot carry the word, most significant byte first. The fourth byte is filler. The loader reads the three useful bytes of each slot, puts the word back together and writes it to the RAM at the slot's index. It works through all 1024 slots of the selected page, in order, and then gives a one-cycle completion pulse.

A start request in idle latches a page number and begins a load. This lets system firmware run an initialisation page first and then swap in a run-time page, whose load overwrites every RAM word. The external memory has a fixed access latency. The loader holds each byte address steady for a parameterised number of wait cycles before it samples the data.

Top module: `boot_pager`

## Requirements
- R1: While reset is high and in the first idle cycle after it, `rom_rd_o`, `ram_we_o`, `busy_o` and `done_o` are all 0.
- R2: A load started in idle with page `p` reads only external byte addresses `{p[2:0], word[9:0], byte[1:0]}`, where `word` is the RAM index being rebuilt and `byte` is the position inside its slot.
- R3: The RAM word for index `w` is `{B0, B1, B2}`: slot byte 0 fills bits [23:16], byte 1 fills bits [15:8] and byte 2 fills bits [7:0].
- R4: Slot byte 3 is padding. While `rom_rd_o` is high, the two low address bits are never 3.
- R5: A byte address and `rom_rd_o` stay steady for `WAIT_CYC`+1 cycles, and the byte is sampled at the end of the last of those cycles. The data only has to be valid from the `WAIT_CYC`-th cycle after the address appears. One page load keeps `busy_o` high for `1024*(3*(WAIT_CYC+1)+1)+1` cycles.
- R6: Each word is written with a single-cycle `ram_we_o`. Writes run through indices 0 to 1023 in ascending order, with exactly 1024 writes per load.
- R7: `done_o` is high for exactly one cycle. That cycle is the one right after the write of index 1023.
- R8: A start request while `busy_o` is high is ignored. This includes a request in the final write cycle and in the done cycle. The page, word order and data of the running load do not change, and no new load follows.
- R9: A later start in idle loads another page, and its words replace the earlier RAM contents word for word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load request, acted on only when idle |
| page_i | input | 3 | Page to load, latched with an accepted start |
| rom_rd_o | output | 1 | External memory read strobe |
| rom_addr_o | output | 15 | External memory byte address |
| rom_data_i | input | 8 | External memory read data |
| ram_we_o | output | 1 | Program RAM write enable |
| ram_addr_o | output | 10 | Program RAM word index |
| ram_wdata_o | output | 24 | Rebuilt 24-bit program word |
| busy_o | output | 1 | High from an accepted start through the done cycle |
| done_o | output | 1 | One-cycle load-complete pulse |

## Verification
The two functions that can land in the same cycle are a start request arriving and the end of a running load, where the final word is written and the completion pulse follows. The bench raises start with a different page in the cycle that writes index 1023 and holds it through the done cycle. It also sends a stray start in the middle of a load. The check is that the expected-word queue drains with the original page's data, that the completion pulse appears once at the right cycle, and that busy and the read strobe stay low afterwards, so no second load was launched. The memory model returns a garbage byte until the wait window has passed, which exposes any early sampling.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int unsigned DEF_WORD_W     = 24;
    localparam int unsigned DEF_BYTE_W     = 8;
    localparam int unsigned DEF_SLOT_BYTES = 4;
    localparam int unsigned DEF_WORDS      = 1024;
    localparam int unsigned DEF_PAGES      = 8;
    localparam int unsigned DEF_WAIT_CYC   = 2;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FETCH = 2'd1,
        LD_WRITE = 2'd2,
        LD_DONE  = 2'd3
    } ld_state_e;

    function automatic int unsigned lanes_of(input int unsigned word_w,
                                             input int unsigned byte_w);
        return (word_w + byte_w - 1) / byte_w;
    endfunction

endpackage

// File: rtl/ld_wait_timer.sv
module ld_wait_timer #(
    parameter int unsigned WAIT_CYC = boot_pkg::DEF_WAIT_CYC,
    localparam int unsigned CW = $clog2(WAIT_CYC + 2)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(WAIT_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/ld_sequencer.sv
module ld_sequencer #(
    parameter int unsigned WORDS  = boot_pkg::DEF_WORDS,
    parameter int unsigned PAGES  = boot_pkg::DEF_PAGES,
    parameter int unsigned SLOT_BYTES = boot_pkg::DEF_SLOT_BYTES,
    parameter int unsigned LANES  = 3,
    localparam int unsigned WIDX_W = $clog2(WORDS),
    localparam int unsigned PAGE_W = $clog2(PAGES),
    localparam int unsigned BIDX_W = $clog2(SLOT_BYTES),
    localparam int unsigned ROM_AW = PAGE_W + WIDX_W + BIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAGE_W-1:0] page,
    input  logic              expired,
    output logic              fetching,
    output logic              capture,
    output logic [BIDX_W-1:0] lane,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              write,
    output logic [WIDX_W-1:0] word_idx,
    output logic              done,
    output logic              busy
);
    import boot_pkg::*;

    ld_state_e         state;
    logic [PAGE_W-1:0] page_q;
    logic              last_lane;
    logic              last_word;

    assign fetching  = (state == LD_FETCH);
    assign write     = (state == LD_WRITE);
    assign done      = (state == LD_DONE);
    assign busy      = (state != LD_IDLE);
    assign capture   = fetching && expired;
    assign last_lane = (lane == BIDX_W'(LANES - 1));
    assign last_word = (word_idx == WIDX_W'(WORDS - 1));
    assign rom_addr  = {page_q, word_idx, lane};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= LD_IDLE;
            page_q   <= '0;
            word_idx <= '0;
            lane     <= '0;
        end else begin
            unique case (state)
                LD_IDLE: begin
                    if (start) begin
                        page_q   <= page;
                        word_idx <= '0;
                        lane     <= '0;
                        state    <= LD_FETCH;
                    end
                end
                LD_FETCH: begin
                    if (expired) begin
                        if (last_lane) begin
                            lane  <= '0;
                            state <= LD_WRITE;
                        end else begin
                            lane <= lane + 1'b1;
                        end
                    end
                end
                LD_WRITE: begin
                    if (last_word) begin
                        state <= LD_DONE;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        state    <= LD_FETCH;
                    end
                end
                LD_DONE: begin
                    state <= LD_IDLE;
                end
                default: state <= LD_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ld_word_packer.sv
module ld_word_packer #(
    parameter int unsigned BYTE_W = boot_pkg::DEF_BYTE_W,
    parameter int unsigned LANES  = 3,
    parameter int unsigned BIDX_W = 2,
    localparam int unsigned WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BIDX_W-1:0] lane,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int unsigned HI = WORD_W - 1 - g * BYTE_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                word[HI -: BYTE_W] <= '0;
            end else if (capture && lane == BIDX_W'(g)) begin
                word[HI -: BYTE_W] <= byte_in;
            end
        end
    end
endmodule

// File: rtl/boot_pager.sv
module boot_pager #(
    parameter int unsigned WORD_W     = boot_pkg::DEF_WORD_W,
    parameter int unsigned BYTE_W     = boot_pkg::DEF_BYTE_W,
    parameter int unsigned SLOT_BYTES = boot_pkg::DEF_SLOT_BYTES,
    parameter int unsigned WORDS      = boot_pkg::DEF_WORDS,
    parameter int unsigned PAGES      = boot_pkg::DEF_PAGES,
    parameter int unsigned WAIT_CYC   = boot_pkg::DEF_WAIT_CYC,
    localparam int unsigned LANES  = boot_pkg::lanes_of(WORD_W, BYTE_W),
    localparam int unsigned WIDX_W = $clog2(WORDS),
    localparam int unsigned PAGE_W = $clog2(PAGES),
    localparam int unsigned BIDX_W = $clog2(SLOT_BYTES),
    localparam int unsigned ROM_AW = PAGE_W + WIDX_W + BIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic              rom_rd_o,
    output logic [ROM_AW-1:0] rom_addr_o,
    input  logic [BYTE_W-1:0] rom_data_i,
    output logic              ram_we_o,
    output logic [WIDX_W-1:0] ram_addr_o,
    output logic [WORD_W-1:0] ram_wdata_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              fetching;
    logic              expired;
    logic              capture;
    logic [BIDX_W-1:0] lane;

    ld_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (fetching),
        .expired (expired)
    );

    ld_sequencer #(
        .WORDS      (WORDS),
        .PAGES      (PAGES),
        .SLOT_BYTES (SLOT_BYTES),
        .LANES      (LANES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .page     (page_i),
        .expired  (expired),
        .fetching (fetching),
        .capture  (capture),
        .lane     (lane),
        .rom_addr (rom_addr_o),
        .write    (ram_we_o),
        .word_idx (ram_addr_o),
        .done     (done_o),
        .busy     (busy_o)
    );

    ld_word_packer #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES),
        .BIDX_W (BIDX_W)
    ) u_pack (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .lane    (lane),
        .byte_in (rom_data_i),
        .word    (ram_wdata_o)
    );

    assign rom_rd_o = fetching;
endmodule

// File: rtl/boot_pager_chk.sv
module boot_pager_chk #(
    parameter int unsigned WORDS    = 1024,
    parameter int unsigned LANES    = 3,
    parameter int unsigned WAIT_CYC = 2,
    parameter int unsigned WIDX_W   = 10,
    parameter int unsigned BIDX_W   = 2,
    parameter int unsigned ROM_AW   = 15,
    localparam int unsigned HW = $clog2(WAIT_CYC + 2) + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              rom_rd_o,
    input logic [ROM_AW-1:0] rom_addr_o,
    input logic              ram_we_o,
    input logic [WIDX_W-1:0] ram_addr_o,
    input logic              busy_o,
    input logic              done_o
);
    logic              rd_q;
    logic [ROM_AW-1:0] addr_q;
    logic [HW-1:0]     hold;
    logic [WIDX_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            addr_q <= '0;
            hold   <= '0;
            wcnt   <= '0;
        end else begin
            rd_q   <= rom_rd_o;
            addr_q <= rom_addr_o;
            if (rom_rd_o && rd_q && rom_addr_o == addr_q)
                hold <= hold + 1'b1;
            else
                hold <= '0;
            if (done_o)
                wcnt <= '0;
            else if (ram_we_o)
                wcnt <= wcnt + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!rom_rd_o && !ram_we_o && !done_o));

    p_no_pad_r4: assert property (@(posedge clk) disable iff (rst)
        rom_rd_o |-> (rom_addr_o[BIDX_W-1:0] < BIDX_W'(LANES)));

    p_hold_len_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_q && (!rom_rd_o || rom_addr_o != addr_q)) |-> (hold == HW'(WAIT_CYC)));

    p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
        ram_we_o |=> !ram_we_o);

    p_ram_order_r6: assert property (@(posedge clk) disable iff (rst)
        ram_we_o |-> (ram_addr_o == wcnt));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(ram_we_o) && $past(ram_addr_o) == WIDX_W'(WORDS - 1)));

    p_no_relaunch_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);
endmodule

bind boot_pager boot_pager_chk #(
    .WORDS    (WORDS),
    .LANES    (LANES),
    .WAIT_CYC (WAIT_CYC),
    .WIDX_W   (WIDX_W),
    .BIDX_W   (BIDX_W),
    .ROM_AW   (ROM_AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rom_rd_o   (rom_rd_o),
    .rom_addr_o (rom_addr_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_boot_pager.sv
module tb_boot_pager;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_CYC   = 2;
    localparam int WORDS      = 1024;
    localparam int BUSY_EXP   = WORDS * (3 * (WAIT_CYC + 1) + 1) + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  page;
    logic        rom_rd;
    logic [14:0] rom_addr;
    logic [7:0]  rom_data;
    logic        ram_we;
    logic [9:0]  ram_addr;
    logic [23:0] ram_wdata;
    logic        busy;
    logic        done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boot_pager #(.WAIT_CYC(WAIT_CYC)) dut (
        .clk (clk), .rst (rst), .start_i (start), .page_i (page),
        .rom_rd_o (rom_rd), .rom_addr_o (rom_addr), .rom_data_i (rom_data),
        .ram_we_o (ram_we), .ram_addr_o (ram_addr), .ram_wdata_o (ram_wdata),
        .busy_o (busy), .done_o (done)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_byte(input logic [14:0] a);
        logic [7:0] v;
        v = (a[7:0] ^ a[14:7]) + {a[1:0], a[14:12], 3'b101};
        return v;
    endfunction

    // memory model: garbage until the wait window has passed
    logic [14:0] last_addr;
    int          age;
    always @(posedge clk) begin
        if (!rom_rd || rom_addr != last_addr) age <= 0;
        else if (age < 255) age <= age + 1;
        last_addr <= rom_addr;
    end
    always_comb rom_data = (rom_rd && age >= WAIT_CYC - 1) ? rom_byte(rom_addr) : 8'h3C;

    typedef struct {
        logic [9:0]  a;
        logic [23:0] d;
    } exp_t;
    exp_t exp_q[$];

    logic [2:0] cur_page;
    int pad_viol, page_viol, done_cnt, busy_cyc, cyc, done_cyc, last_cyc;
    logic done_prev;

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected write", ram_addr, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(ram_addr == e.a, "R6 write index", ram_addr, e.a);
                    check(ram_wdata == e.d, "R2 R3 R9 word data", ram_wdata, e.d);
                end
                if (ram_addr == 10'd1023) last_cyc = cyc;
            end
            if (rom_rd) begin
                if (rom_addr[1:0] == 2'd3) pad_viol++;
                if (rom_addr[14:12] != cur_page) page_viol++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
                if (done_prev) check(0, "R7 done longer than one cycle", 2, 1);
            end
            if (busy) busy_cyc++;
            done_prev = done;
            cyc++;
        end
    end

    task automatic push_page(input logic [2:0] p);
        for (int w = 0; w < WORDS; w++) begin
            exp_t e;
            logic [14:0] base;
            base = {p, 10'(w), 2'b00};
            e.a = 10'(w);
            e.d = {rom_byte(base), rom_byte(base | 15'd1), rom_byte(base | 15'd2)};
            exp_q.push_back(e);
        end
    endtask

    task automatic arm(input logic [2:0] p);
        cur_page  = p;
        pad_viol  = 0;
        page_viol = 0;
        done_cnt  = 0;
        busy_cyc  = 0;
        done_cyc  = -1;
        last_cyc  = -100;
        push_page(p);
        @(negedge clk);
        start = 1'b1;
        page  = p;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_checks(input string tag);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, {"R6 all words written ", tag}, exp_q.size(), 0);
        check(done_cnt == 1, {"R7 one done pulse ", tag}, done_cnt, 1);
        check(done_cyc == last_cyc + 1, {"R7 done after last write ", tag}, done_cyc, last_cyc + 1);
        check(pad_viol == 0, {"R4 padding never read ", tag}, pad_viol, 0);
        check(page_viol == 0, {"R2 page field ", tag}, page_viol, 0);
        check(busy_cyc == BUSY_EXP, {"R5 load length ", tag}, busy_cyc, BUSY_EXP);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        page  = 3'd0;
        cur_page = 3'd0;
        done_prev = 1'b0;
        cyc = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!rom_rd, "R1 rd in reset", rom_rd, 0);
        check(!ram_we, "R1 we in reset", ram_we, 0);
        check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rom_rd && !done && !ram_we, "R1 idle after reset",
              {busy, rom_rd, done, ram_we}, 0);

        // plain load of the init page
        arm(3'd0);
        finish_checks("page0");

        // run-time page with stray starts, including at the end of the load
        arm(3'd5);
        while (!(ram_we && ram_addr == 10'd300)) @(negedge clk);
        start = 1'b1;
        page  = 3'd2;
        @(negedge clk);
        start = 1'b0;
        while (!(ram_we && ram_addr == 10'd1023)) @(negedge clk);
        start = 1'b1;
        page  = 3'd1;
        finish_checks("page5 R8");
        start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!busy && !rom_rd, "R8 no relaunch after ignored start", {busy, rom_rd}, 0);
        end

        // replacement with a third page
        arm(3'd7);
        finish_checks("page7 R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule